// File: doc/BRIEF.md
# Display-identification EEPROM-emulating I2C slave

This block sits on a two-wire display-data bus and behaves like a small serial EEPROM that holds display identification data. The bytes themselves live in a 256-entry RAM outside the block. The host side of the chip reaches that RAM through its other port; this block uses one read/write port. The block samples SCL and SDA through a synchroniser. It pulls SDA low through an open-drain enable (`sda_oe` = 1 means the line is driven low). It recognises START, repeated START and STOP, and it answers three device addresses.

A master first writes one data-address byte, which loads the internal pointer. Any data bytes that follow are stored at the pointer, one after another. To read, the master either continues from the pointer (current-address read), or sends a dummy write of the data address, then a repeated START and a read address (random read). It keeps acknowledging to stream consecutive bytes. All three device addresses share the one RAM and the one pointer. The device address chooses only how the pointer wraps: 8-bit wrap for two of them, and a low-7-bit wrap that keeps the pointer's top bit for the third.

On the host side there are a write-protect input, an end-of-write flag with its interrupt enable and a write-one-to-clear strobe, and the RAM port.

Top module: `ddc_slave`

## Requirements
- R1: After reset, `sda_oe`, `edf_flag` and `irq` are 0.
- R2: The block acknowledges a device byte whose upper 7 bits are 7'h50, 7'h51 or 7'h53, for both R/W values (bit 0; 0 = write, 1 = read). Any other address is not acknowledged. After such an address, further bytes are not acknowledged and RAM is untouched until the next START.
- R3: In a write, the byte after the device address is acknowledged and loaded into the pointer. Every later data byte is acknowledged, written to RAM at the pointer, and the pointer then advances.
- R4: When `wr_prot` is 1, write data bytes are still acknowledged, but the RAM is left unchanged.
- R5: When the device address is 7'h51 or 7'h53, the pointer advances through all 8 bits and wraps from FFh to 00h.
- R6: When the device address is 7'h50, only the low 7 bits of the pointer advance, so the pointer wraps from 7Fh to 00h and from FFh to 80h.
- R7: A dummy write of a data address, then a repeated START and a read address, returns the byte at that address. Each master ACK (SDA low on the 9th clock) yields the next byte in the pointer order.
- R8: The pointer advances after every byte read, including the last byte, which the master does not acknowledge. A later current-address read therefore continues from the following location.
- R9: After a master NACK on a read byte, the block releases SDA (`sda_oe` = 0) and drives it no more until the next START.
- R10: `edf_flag` goes to 1 on a STOP that follows at least one data byte actually stored (not write-protected) since the last START. A dummy write or a protected write does not set it. `edf_clr` = 1 clears it. `irq` equals `edf_flag` AND `edf_irq_en`.
- R11: A START or STOP at any bit position of a byte restarts bit counting, so the next transfer is decoded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| wr_prot | input | 1 | 1 discards bus writes |
| edf_irq_en | input | 1 | Interrupt enable for the end-of-write flag |
| edf_clr | input | 1 | Write-one-to-clear strobe for the flag |
| edf_flag | output | 1 | End-of-write flag |
| irq | output | 1 | Interrupt request |
| ram_addr | output | 8 | RAM address (the pointer) |
| ram_we | output | 1 | RAM write strobe, one cycle |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data for `ram_addr`, combinational |

## Verification
Transfers are tried against all three device addresses. Data addresses are placed just below 7Fh and FFh, so that only the correct wrap rule reads back the written bytes. Each data address is also reached once through the 8-bit rule and once through the 7-bit rule. Writes with protection on and off tell discarding apart from storing. Random reads, current reads and foreign addresses tell pointer loading from pointer continuation and from ignoring the bus. Aborted partial bytes show whether START and STOP really restart bit counting. Flag checks after data writes, dummy writes and protected writes separate a stored byte from a merely acknowledged one.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  localparam int PTR_W  = 8;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_SUB,
    ST_WR,
    ST_RD
  } ddc_state_t;

  // Next pointer: low bits always count; the top bit carries only in wide mode.
  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p,
                                                input logic wide);
    logic [PTR_W-2:0] lo;
    logic             top;
    lo  = p[PTR_W-2:0] + 1'b1;
    top = wide ? (p[PTR_W-1] ^ (&p[PTR_W-2:0])) : p[PTR_W-1];
    return {top, lo};
  endfunction
endpackage

// File: rtl/ddc_line_sync.sv
module ddc_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_s,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_q, sda_q, scl_s;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/ddc_ptr.sv
module ddc_ptr
  import ddc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             step,
  input  logic             wide,
  output logic [PTR_W-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (step) ptr <= ptr_step(ptr, wide);
  end
endmodule

// File: rtl/ddc_slave.sv
module ddc_slave
  import ddc_pkg::*;
#(
  parameter logic [6:0] DEV_NARROW  = 7'h50,
  parameter logic [6:0] DEV_WIDE_A  = 7'h51,
  parameter logic [6:0] DEV_WIDE_B  = 7'h53,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              wr_prot,
  input  logic              edf_irq_en,
  input  logic              edf_clr,
  output logic              edf_flag,
  output logic              irq,
  output logic [PTR_W-1:0]  ram_addr,
  output logic              ram_we,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(DATA_W + 1);

  ddc_state_t        state;
  logic [CNT_W-1:0]  bitcnt;
  logic [DATA_W-1:0] rx_sr, tx_sr;
  logic              ack_q, tx_en, rw_q, wide_q, mack_q, wrote_q;

  // Named internal events
  logic scl_rise, scl_fall, sda_s, start_evt, stop_evt;
  logic byte_done, ack_done, dev_match, dev_wide, ptr_load, ptr_step_evt;
  logic receiving;
  logic [PTR_W-1:0] ptr;

  ddc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .start_det(start_evt), .stop_det(stop_evt)
  );

  assign byte_done    = scl_fall && (bitcnt == LAST_BIT) && (state != ST_IDLE);
  assign ack_done     = scl_fall && (bitcnt == ACK_BIT)  && (state != ST_IDLE);
  assign dev_wide     = (rx_sr[7:1] == DEV_WIDE_A) || (rx_sr[7:1] == DEV_WIDE_B);
  assign dev_match    = dev_wide || (rx_sr[7:1] == DEV_NARROW);
  assign receiving    = (state == ST_DEV) || (state == ST_SUB) || (state == ST_WR);
  assign ptr_load     = byte_done && (state == ST_SUB) && !start_evt && !stop_evt;
  assign ptr_step_evt = ((ack_done && state == ST_WR) || (byte_done && state == ST_RD))
                        && !start_evt && !stop_evt;

  ddc_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(rx_sr),
    .step(ptr_step_evt), .wide(wide_q), .ptr(ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      ack_q     <= 1'b0;
      tx_en     <= 1'b0;
      rw_q      <= 1'b0;
      wide_q    <= 1'b0;
      mack_q    <= 1'b0;
      wrote_q   <= 1'b0;
      edf_flag  <= 1'b0;
      ram_we    <= 1'b0;
      ram_wdata <= '0;
    end else begin
      ram_we <= 1'b0;
      if (edf_clr)             edf_flag <= 1'b0;
      if (stop_evt && wrote_q) edf_flag <= 1'b1;

      if (start_evt) begin
        state   <= ST_DEV;
        bitcnt  <= '0;
        ack_q   <= 1'b0;
        tx_en   <= 1'b0;
        wrote_q <= 1'b0;
      end else if (stop_evt) begin
        state  <= ST_IDLE;
        bitcnt <= '0;
        ack_q  <= 1'b0;
        tx_en  <= 1'b0;
      end else begin
        if (scl_rise && state != ST_IDLE && bitcnt < ACK_BIT) begin
          bitcnt <= bitcnt + 1'b1;
          if (receiving && bitcnt < LAST_BIT) rx_sr <= {rx_sr[DATA_W-2:0], sda_s};
          if (state == ST_RD && bitcnt == LAST_BIT) mack_q <= ~sda_s;
        end

        if (scl_fall && state == ST_RD && bitcnt != '0 && bitcnt < LAST_BIT)
          tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};

        if (byte_done) begin
          case (state)
            ST_DEV: begin
              if (dev_match) begin
                ack_q  <= 1'b1;
                rw_q   <= rx_sr[0];
                wide_q <= dev_wide;
              end else begin
                state  <= ST_IDLE;
                bitcnt <= '0;
              end
            end
            ST_SUB: ack_q <= 1'b1;
            ST_WR: begin
              ack_q <= 1'b1;
              if (!wr_prot) begin
                ram_we    <= 1'b1;
                ram_wdata <= rx_sr;
                wrote_q   <= 1'b1;
              end
            end
            ST_RD:   tx_en <= 1'b0;
            default: ;
          endcase
        end

        if (ack_done) begin
          ack_q  <= 1'b0;
          bitcnt <= '0;
          case (state)
            ST_DEV: begin
              if (rw_q) begin
                state <= ST_RD;
                tx_sr <= ram_rdata;
                tx_en <= 1'b1;
              end else begin
                state <= ST_SUB;
              end
            end
            ST_SUB: state <= ST_WR;
            ST_RD: begin
              if (mack_q) begin
                tx_sr <= ram_rdata;
                tx_en <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign sda_oe   = ack_q | (tx_en & ~tx_sr[DATA_W-1]);
  assign irq      = edf_flag & edf_irq_en;
  assign ram_addr = ptr;
endmodule

// File: rtl/ddc_slave_chk.sv
module ddc_slave_chk
  import ddc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sda_oe,
  input logic             wr_prot,
  input logic             edf_flag,
  input logic             irq,
  input logic             ram_we,
  input logic [PTR_W-1:0] ram_addr,
  input logic             stop_evt,
  input logic             ptr_step_evt,
  input logic             wide_q
);
  // R11: a STOP ends any drive of SDA
  assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  // R4: a RAM write only follows a byte taken while protection was off
  assert_wp_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> !$past(wr_prot));

  // R3: a stored byte is acknowledged at the same time
  assert_write_acked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> sda_oe);

  // R6: narrow mode never changes the pointer's top bit
  assert_narrow_msb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_step_evt && !wide_q) |=> (ram_addr[PTR_W-1] == $past(ram_addr[PTR_W-1])));

  // R5: wide mode wraps the full pointer to zero
  assert_wide_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_step_evt && wide_q && (&ram_addr)) |=> (ram_addr == '0));

  // R10: the flag rises only after a STOP; the interrupt needs the flag
  assert_edf_on_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(edf_flag) |-> $past(stop_evt));
  assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> edf_flag);
endmodule

bind ddc_slave ddc_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .wr_prot(wr_prot),
  .edf_flag(edf_flag), .irq(irq), .ram_we(ram_we), .ram_addr(ram_addr),
  .stop_evt(stop_evt), .ptr_step_evt(ptr_step_evt), .wide_q(wide_q)
);

// File: tb/ddc_slave_bench.sv
module ddc_slave_bench;
  localparam int HP = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda_low = 1'b0;
  logic wr_prot = 1'b0, edf_irq_en = 1'b0, edf_clr = 1'b0;
  logic sda_oe, edf_flag, irq, ram_we;
  logic [7:0] ram_addr, ram_wdata, ram_rdata;
  logic sda_line;
  logic [7:0] mem [0:255];
  logic [7:0] exp_mem [0:255];
  logic [7:0] exp_ptr = 8'h00;
  logic [7:0] wbuf [0:7];
  logic exp_edf = 1'b0;
  int vectors = 0, errors = 0;

  always #4 clk = ~clk;

  assign sda_line  = ~(m_sda_low | sda_oe);
  assign ram_rdata = mem[ram_addr];

  ddc_slave u_ddc_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .wr_prot(wr_prot), .edf_irq_en(edf_irq_en), .edf_clr(edf_clr),
    .edf_flag(edf_flag), .irq(irq), .ram_addr(ram_addr), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
    end else if (ram_we) begin
      mem[ram_addr] <= ram_wdata;
    end
  end

  function automatic logic [7:0] b_step(input logic [7:0] p, input bit wide);
    if (wide) return p + 8'd1;
    return (p & 8'h80) | ((p + 8'd1) & 8'h7F);
  endfunction

  function automatic bit is_wide(input logic [6:0] dev);
    return (dev == 7'h51) || (dev == 7'h53);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic hp();
    repeat (HP) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; hp();
    m_scl = 1'b1;     hp();
    m_sda_low = 1'b1; hp();
    m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; hp();
    m_scl = 1'b1;     hp();
    m_sda_low = 1'b0; hp();
  endtask

  task automatic send_bit(input logic b);
    m_sda_low = ~b; hp();
    m_scl = 1'b1;   hp();
    m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda_low = 1'b0; hp();
    m_scl = 1'b1;
    repeat (HP / 2) @(negedge clk);
    ack = ~sda_line;
    repeat (HP / 2) @(negedge clk);
    m_scl = 1'b0;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    m_sda_low = 1'b0;
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      hp();
      m_scl = 1'b1;
      repeat (HP / 2) @(negedge clk);
      b = {b[6:0], sda_line};
      repeat (HP / 2) @(negedge clk);
      m_scl = 1'b0;
    end
    m_sda_low = mack; hp();
    m_scl = 1'b1;     hp();
    m_scl = 1'b0;
    m_sda_low = 1'b0;
  endtask

  task automatic xact_write(input logic [6:0] dev, input logic [7:0] sub, input int n);
    logic ack;
    bit w;
    w = is_wide(dev);
    bus_start();
    send_byte({dev, 1'b0}, ack); check("R2 device ack (write)", {7'd0, ack}, 8'd1);
    send_byte(sub, ack);         check("R3 data-address ack", {7'd0, ack}, 8'd1);
    exp_ptr = sub;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);
      check(wr_prot ? "R4 protected byte ack" : "R3 data byte ack", {7'd0, ack}, 8'd1);
      if (!wr_prot) begin
        exp_mem[exp_ptr] = wbuf[i];
        exp_edf = 1'b1;
      end
      exp_ptr = b_step(exp_ptr, w);
    end
    bus_stop();
  endtask

  task automatic read_run(input logic [6:0] dev, input int n, input string tag);
    logic ack;
    logic [7:0] b;
    bit w;
    w = is_wide(dev);
    send_byte({dev, 1'b1}, ack); check("R2 device ack (read)", {7'd0, ack}, 8'd1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      check(tag, b, exp_mem[exp_ptr]);
      exp_ptr = b_step(exp_ptr, w);
    end
    repeat (6) @(negedge clk);
    check("R9 SDA released after NACK", {7'd0, sda_oe}, 8'd0);
    bus_stop();
  endtask

  task automatic xact_rand_read(input logic [6:0] dev, input logic [7:0] sub, input int n);
    logic ack;
    bus_start();
    send_byte({dev, 1'b0}, ack); check("R2 device ack (dummy)", {7'd0, ack}, 8'd1);
    send_byte(sub, ack);         check("R7 dummy address ack", {7'd0, ack}, 8'd1);
    exp_ptr = sub;
    bus_start();
    read_run(dev, n, "R7 random/sequential read data");
  endtask

  task automatic xact_cur_read(input logic [6:0] dev, input int n);
    bus_start();
    read_run(dev, n, "R8 current-address read data");
  endtask

  task automatic pulse_clr();
    edf_clr = 1'b1; @(negedge clk);
    edf_clr = 1'b0; @(negedge clk);
    exp_edf = 1'b0;
  endtask

  task automatic check_flag(input string tag);
    repeat (4) @(negedge clk);
    check(tag, {7'd0, edf_flag}, {7'd0, exp_edf});
    check("R10 irq follows flag and enable", {7'd0, irq}, {7'd0, exp_edf & edf_irq_en});
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin : main
    logic ack;
    logic [6:0] devs [0:2];
    logic [7:0] subs [0:3];
    devs[0] = 7'h50; devs[1] = 7'h51; devs[2] = 7'h53;
    subs[0] = 8'h7E; subs[1] = 8'h7F; subs[2] = 8'hFE; subs[3] = 8'hFF;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
    repeat (5) @(negedge clk);
    check("R1 sda_oe after reset", {7'd0, sda_oe}, 8'd0);
    check("R1 flag after reset", {7'd0, edf_flag}, 8'd0);
    check("R1 irq after reset", {7'd0, irq}, 8'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R6: narrow wrap 7F->00 and FF->80
    for (int i = 0; i < 4; i++) wbuf[i] = 8'hC0 + 8'(i);
    xact_write(7'h50, 8'h7E, 4);
    xact_rand_read(7'h50, 8'h7E, 4);
    check("R6 narrow wrap low half", exp_mem[8'h00], 8'hC2);
    for (int i = 0; i < 4; i++) wbuf[i] = 8'hD0 + 8'(i);
    xact_write(7'h50, 8'hFE, 4);
    xact_rand_read(7'h50, 8'hFE, 4);
    check("R6 narrow wrap high half", exp_mem[8'h80], 8'hD2);

    // R5: wide wrap FF->00 through both wide addresses
    for (int i = 0; i < 3; i++) wbuf[i] = 8'hE0 + 8'(i);
    xact_write(7'h51, 8'hFF, 3);
    xact_rand_read(7'h53, 8'hFF, 3);
    check("R5 wide wrap", exp_mem[8'h00], 8'hE1);

    // R8: current read continues after the NACKed byte
    xact_cur_read(7'h51, 2);

    // R10: flag and interrupt
    pulse_clr();
    edf_irq_en = 1'b1;
    wbuf[0] = 8'h5A; wbuf[1] = 8'hA5;
    xact_write(7'h53, 8'h20, 2);
    check_flag("R10 flag after stored write");
    pulse_clr();
    check_flag("R10 flag cleared by strobe");
    edf_irq_en = 1'b0;
    xact_write(7'h51, 8'h30, 1);
    check_flag("R10 flag with interrupt disabled");
    pulse_clr();
    xact_write(7'h50, 8'h40, 0);
    check_flag("R10 dummy write leaves flag clear");

    // R4: protected write acked, RAM unchanged, flag not set
    wr_prot = 1'b1;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    xact_write(7'h50, 8'h10, 2);
    check_flag("R4 protected write leaves flag clear");
    wr_prot = 1'b0;
    xact_rand_read(7'h50, 8'h10, 2);

    // R2: foreign address ignored until next START
    bus_start();
    send_byte({7'h54, 1'b0}, ack); check("R2 foreign address NACK", {7'd0, ack}, 8'd0);
    send_byte(8'h10, ack);         check("R2 ignored byte NACK", {7'd0, ack}, 8'd0);
    send_byte(8'h99, ack);         check("R2 ignored data NACK", {7'd0, ack}, 8'd0);
    bus_stop();
    bus_start();
    send_byte({7'h52, 1'b1}, ack); check("R2 foreign read NACK", {7'd0, ack}, 8'd0);
    bus_stop();
    xact_rand_read(7'h51, 8'h10, 1);

    // R11: START and STOP inside a byte restart bit counting
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    wbuf[0] = 8'h77;
    xact_write(7'h53, 8'h60, 1);
    bus_start();
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    bus_stop();
    xact_rand_read(7'h50, 8'h60, 1);
    check("R11 byte stored after aborted bits", exp_mem[8'h60], 8'h77);
    pulse_clr();

    // Random mix
    for (int t = 0; t < 30; t++) begin
      logic [6:0] dev;
      logic [7:0] sub;
      int op, n;
      dev = devs[$urandom_range(0, 2)];
      sub = ($urandom_range(0, 1) == 0) ? subs[$urandom_range(0, 3)] : 8'($urandom);
      op  = $urandom_range(0, 2);
      n   = $urandom_range(1, 4);
      wr_prot = ($urandom_range(0, 3) == 0);
      if (op == 0) begin
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
        xact_write(dev, sub, n);
      end else if (op == 1) begin
        xact_rand_read(dev, sub, n);
      end else begin
        xact_cur_read(dev, n);
      end
      check_flag("R10 flag after random transfer");
      pulse_clr();
    end
    wr_prot = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule